// File: doc/BRIEF.md
# Three-Byte Receive Word Packer

This block takes bytes from a peer device over a ready/strobe handshake, stores them in a 64-entry byte queue, and packs them into 24-bit words for a host that reads whole words. The peer raises its ready line with a byte on the data lines. The block accepts the byte when it has room and answers with an active-low strobe of fixed width. An assembler draws bytes from the queue three at a time and fills a word register. It raises a sequence flag while a word is partly built and a ready flag once the word is complete. When the host reads the word, the next word can be built.

The peer's ready line is disregarded from reset or module clear until the link layer reports that the four-byte header has gone out. This stops stale peer data from entering the queue before a transaction is set up. A header load flushes the byte queue. A word that takes too long to complete is abandoned, and a single-cycle timeout pulse is raised for the status logic to latch. Command decoding and status assembly are handled elsewhere.

Top module: `rx_word_packer`

## Requirements
- R1: After reset or a clear pulse, the outputs read as follows: strobe high, sequence flag low, ready flag low, queue-room flag high and timeout pulse low.
- R2: From reset, and again from any clear pulse, the peer ready input is ignored until one `hdr_done_i` pulse has been seen. During that time no strobe is issued and no byte is stored.
- R3: A byte is accepted in a cycle where peer ready is high, the mask is lifted and the queue has room. After acceptance, the strobe is driven low for exactly `STROBE_CYCLES` cycles. Each acceptance stores exactly one byte.
- R4: The queue holds 64 bytes. `fifo_room_o` is high while the queue is not full. While the queue is full, no byte is accepted.
- R5: Bytes are packed in arrival order. The first byte of a word lands in bits 23..16, the second in bits 15..8 and the third in bits 7..0.
- R6: `seq_o` is high from the cycle after a word's first byte is taken until its third byte is taken. `rdy_o` is high from the cycle after the third byte is taken until the word is read. The two flags are never high together.
- R7: A read strobe while `rdy_o` is high clears `rdy_o` on the next cycle. The first byte of the next word may be taken in that same cycle. A read strobe while `rdy_o` is low has no effect.
- R8: While a word is held and not read, no byte is taken from the queue, and `word_o` stays unchanged.
- R9: If `seq_o` stays high for `TIMEOUT_CYCLES` cycles (20 ms by default at 100 MHz), the partial word is discarded. `tto_set_o` then pulses high for one cycle with `seq_o` low, and the next word starts from a fresh first byte.
- R10: A header-load pulse empties the byte queue. It leaves the held word, the ready flag and the mask state unchanged.
- R11: A clear pulse empties the queue, discards the held and partial words, and takes priority over a byte acceptance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| clear_i | input | 1 | Module clear pulse |
| hdr_load_i | input | 1 | Header register load pulse; flushes the byte queue |
| hdr_done_i | input | 1 | Pulse when the fourth header byte has been sent; lifts the mask |
| peer_rdy_i | input | 1 | Peer has a byte on the data lines |
| peer_data_i | input | BYTE_W | Byte from the peer |
| peer_stb_n_o | output | 1 | Active-low acknowledge strobe to the peer |
| word_rd_i | input | 1 | Host reads the word register |
| word_o | output | BYTE_W*WORD_BYTES | Assembled word |
| seq_o | output | 1 | Word assembly in progress |
| rdy_o | output | 1 | Complete word held and unread |
| fifo_room_o | output | 1 | Byte queue is not full |
| tto_set_o | output | 1 | One-cycle pulse when assembly times out |

## Verification
Two events can fall in the same cycle: the host read that releases a held word, and the assembler taking the first byte of the following word. The bench sets this up by stopping automatic reads, streaming two words so the second waits in the queue behind a held first word, and then issuing one read. The check requires that, one cycle later, the ready flag is low and the sequence flag is high. Two cycles after that, the ready flag must be high again with the second word's bytes in order. A second collision, a clear arriving against a held word and a waiting byte, is judged by the reset-like outputs and by the re-armed mask.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

    typedef enum logic [1:0] {
        LK_IDLE   = 2'd0,
        LK_STROBE = 2'd1,
        LK_GAP    = 2'd2
    } link_st_e;

    typedef struct packed {
        logic empty;
        logic full;
    } fifo_flags_t;

    // True when a queue of the given fill state can take another entry.
    function automatic logic has_room(input fifo_flags_t f);
        return !f.full;
    endfunction

    // True when a queue of the given fill state can deliver an entry.
    function automatic logic has_data(input fifo_flags_t f);
        return !f.empty;
    endfunction

endpackage

// File: rtl/rxw_link.sv
module rxw_link
    import rxw_pkg::*;
#(
    parameter int BYTE_W        = 8,
    parameter int STROBE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              hdr_load_i,
    input  logic              hdr_done_i,
    input  logic              peer_rdy_i,
    input  logic              room_i,
    output logic              accept_o,
    output logic              peer_stb_n_o
);
    localparam int CW = (STROBE_CYCLES > 1) ? $clog2(STROBE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(STROBE_CYCLES - 1);

    link_st_e        st_q;
    logic [CW-1:0]   cnt_q;
    logic            masked_q;
    logic            stb_n_q;

    assign accept_o = (st_q == LK_IDLE) && !masked_q && peer_rdy_i && room_i
                      && !clear_i && !hdr_load_i;
    assign peer_stb_n_o = stb_n_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            masked_q <= 1'b1;
        end else if (hdr_done_i) begin
            masked_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            st_q    <= LK_IDLE;
            cnt_q   <= '0;
            stb_n_q <= 1'b1;
        end else begin
            unique case (st_q)
                LK_IDLE: begin
                    if (accept_o) begin
                        st_q    <= LK_STROBE;
                        cnt_q   <= '0;
                        stb_n_q <= 1'b0;
                    end
                end
                LK_STROBE: begin
                    if (cnt_q == LAST) begin
                        st_q    <= LK_GAP;
                        stb_n_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                LK_GAP: begin
                    st_q <= LK_IDLE;
                end
                default: begin
                    st_q    <= LK_IDLE;
                    stb_n_q <= 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/rxw_fifo.sv
module rxw_fifo
    import rxw_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_o,
    output fifo_flags_t       flags_o
);
    localparam int AW = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW:0]       wptr_q;
    logic [AW:0]       rptr_q;
    logic              do_push;
    logic              do_pop;

    assign flags_o.empty = (wptr_q == rptr_q);
    assign flags_o.full  = (wptr_q[AW] != rptr_q[AW]) &&
                           (wptr_q[AW-1:0] == rptr_q[AW-1:0]);

    assign do_push = push_i && has_room(flags_o) && !flush_i;
    assign do_pop  = pop_i && has_data(flags_o) && !flush_i;
    assign head_o  = mem[rptr_q[AW-1:0]];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr_q[AW-1:0]] <= push_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (do_push) wptr_q <= wptr_q + 1'b1;
            if (do_pop)  rptr_q <= rptr_q + 1'b1;
        end
    end

endmodule

// File: rtl/rxw_pack.sv
module rxw_pack
    import rxw_pkg::*;
#(
    parameter int BYTE_W         = 8,
    parameter int WORD_BYTES     = 3,
    parameter int TIMEOUT_CYCLES = 2_000_000
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear_i,
    input  logic [BYTE_W-1:0]            byte_i,
    input  logic                         avail_i,
    input  logic                         rd_i,
    output logic                         pop_o,
    output logic [BYTE_W*WORD_BYTES-1:0] word_o,
    output logic                         seq_o,
    output logic                         rdy_o,
    output logic                         tto_o
);
    localparam int WORD_W = BYTE_W * WORD_BYTES;
    localparam int IW     = $clog2(WORD_BYTES);
    localparam int TW     = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [IW-1:0] LAST_IDX = IW'(WORD_BYTES - 1);
    localparam logic [TW-1:0] TMR_END  = TW'(TIMEOUT_CYCLES - 1);

    logic [IW-1:0]     idx_q;
    logic [TW-1:0]     tmr_q;
    logic [WORD_W-1:0] build_q;
    logic [WORD_W-1:0] out_q;
    logic              rdy_q;
    logic              tto_q;
    logic              expire;
    logic              last;
    logic [WORD_W-1:0] shifted;

    assign seq_o   = (idx_q != '0);
    assign expire  = seq_o && (tmr_q == TMR_END);
    assign last    = (idx_q == LAST_IDX);
    assign pop_o   = avail_i && (!rdy_q || rd_i) && !expire && !clear_i;
    assign shifted = {build_q[WORD_W-BYTE_W-1:0], byte_i};

    assign word_o = out_q;
    assign rdy_o  = rdy_q;
    assign tto_o  = tto_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            idx_q   <= '0;
            tmr_q   <= '0;
            build_q <= '0;
            out_q   <= '0;
            rdy_q   <= 1'b0;
            tto_q   <= 1'b0;
        end else begin
            tto_q <= expire;
            if (expire) begin
                idx_q <= '0;
                tmr_q <= '0;
            end else begin
                if (seq_o && !(pop_o && last)) tmr_q <= tmr_q + 1'b1;
                else                           tmr_q <= '0;
                if (pop_o) begin
                    build_q <= shifted;
                    if (last) idx_q <= '0;
                    else      idx_q <= idx_q + 1'b1;
                end
            end
            if (pop_o && last && !expire) begin
                out_q <= shifted;
                rdy_q <= 1'b1;
            end else if (rd_i) begin
                rdy_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rx_word_packer.sv
module rx_word_packer
    import rxw_pkg::*;
#(
    parameter int BYTE_W         = 8,
    parameter int WORD_BYTES     = 3,
    parameter int FIFO_DEPTH     = 64,
    parameter int STROBE_CYCLES  = 4,
    parameter int TIMEOUT_CYCLES = 2_000_000
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear_i,
    input  logic                         hdr_load_i,
    input  logic                         hdr_done_i,
    input  logic                         peer_rdy_i,
    input  logic [BYTE_W-1:0]            peer_data_i,
    output logic                         peer_stb_n_o,
    input  logic                         word_rd_i,
    output logic [BYTE_W*WORD_BYTES-1:0] word_o,
    output logic                         seq_o,
    output logic                         rdy_o,
    output logic                         fifo_room_o,
    output logic                         tto_set_o
);
    logic              accept;
    logic              pop;
    logic [BYTE_W-1:0] head;
    fifo_flags_t       flags;

    assign fifo_room_o = has_room(flags);

    rxw_link #(
        .BYTE_W        (BYTE_W),
        .STROBE_CYCLES (STROBE_CYCLES)
    ) u_link (
        .clk          (clk),
        .rst          (rst),
        .clear_i      (clear_i),
        .hdr_load_i   (hdr_load_i),
        .hdr_done_i   (hdr_done_i),
        .peer_rdy_i   (peer_rdy_i),
        .room_i       (fifo_room_o),
        .accept_o     (accept),
        .peer_stb_n_o (peer_stb_n_o)
    );

    rxw_fifo #(
        .DATA_W (BYTE_W),
        .DEPTH  (FIFO_DEPTH)
    ) u_fifo (
        .clk         (clk),
        .rst         (rst),
        .flush_i     (clear_i || hdr_load_i),
        .push_i      (accept),
        .push_data_i (peer_data_i),
        .pop_i       (pop),
        .head_o      (head),
        .flags_o     (flags)
    );

    rxw_pack #(
        .BYTE_W         (BYTE_W),
        .WORD_BYTES     (WORD_BYTES),
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
    ) u_pack (
        .clk     (clk),
        .rst     (rst),
        .clear_i (clear_i),
        .byte_i  (head),
        .avail_i (has_data(flags) && !hdr_load_i),
        .rd_i    (word_rd_i),
        .pop_o   (pop),
        .word_o  (word_o),
        .seq_o   (seq_o),
        .rdy_o   (rdy_o),
        .tto_o   (tto_set_o)
    );

endmodule

// File: rtl/rxw_checks.sv
module rxw_checks #(
    parameter int WORD_W        = 24,
    parameter int STROBE_CYCLES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              clear_i,
    input logic              hdr_done_i,
    input logic              peer_stb_n_o,
    input logic              word_rd_i,
    input logic [WORD_W-1:0] word_o,
    input logic              seq_o,
    input logic              rdy_o,
    input logic              fifo_room_o,
    input logic              tto_set_o
);
    logic        open_q;
    logic [15:0] low_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i)  open_q <= 1'b0;
        else if (hdr_done_i) open_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || peer_stb_n_o) low_q <= '0;
        else                     low_q <= low_q + 1'b1;
    end

    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (peer_stb_n_o && !seq_o && !rdy_o && fifo_room_o && !tto_set_o));

    a_r2_masked: assert property (@(posedge clk) disable iff (rst)
        $fell(peer_stb_n_o) |-> $past(open_q));

    a_r3_strobe_width: assert property (@(posedge clk) disable iff (rst)
        ($rose(peer_stb_n_o) && !$past(clear_i)) |-> (low_q == 16'(STROBE_CYCLES)));

    a_r4_no_accept_full: assert property (@(posedge clk) disable iff (rst)
        $fell(peer_stb_n_o) |-> $past(fifo_room_o));

    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(seq_o && rdy_o));

    a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rdy_o && word_rd_i && !clear_i) |=> !rdy_o);

    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst || clear_i)
        (rdy_o && !word_rd_i) |=> (rdy_o && $stable(word_o)));

    a_r9_tto_no_seq: assert property (@(posedge clk) disable iff (rst)
        tto_set_o |-> !seq_o);

    a_r9_tto_single: assert property (@(posedge clk) disable iff (rst)
        tto_set_o |=> !tto_set_o);

endmodule

bind rx_word_packer rxw_checks #(
    .WORD_W        (BYTE_W * WORD_BYTES),
    .STROBE_CYCLES (STROBE_CYCLES)
) u_checks (
    .clk          (clk),
    .rst          (rst),
    .clear_i      (clear_i),
    .hdr_done_i   (hdr_done_i),
    .peer_stb_n_o (peer_stb_n_o),
    .word_rd_i    (word_rd_i),
    .word_o       (word_o),
    .seq_o        (seq_o),
    .rdy_o        (rdy_o),
    .fifo_room_o  (fifo_room_o),
    .tto_set_o    (tto_set_o)
);

// File: tb/rx_word_packer_test.sv
module rx_word_packer_test;
    localparam int STB = 3;
    localparam int TMO = 200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clear_i = 1'b0;
    logic        hdr_load_i = 1'b0;
    logic        hdr_done_i = 1'b0;
    logic        peer_rdy_i = 1'b0;
    logic [7:0]  peer_data_i = 8'h00;
    logic        peer_stb_n_o;
    logic        word_rd_i = 1'b0;
    logic [23:0] word_o;
    logic        seq_o, rdy_o, fifo_room_o, tto_set_o;

    int n_chk = 0;
    int n_fail = 0;
    bit auto_read = 1'b0;
    bit done = 1'b0;
    logic [23:0] exp_q[$];

    always #5 clk = ~clk;

    rx_word_packer #(.STROBE_CYCLES(STB), .TIMEOUT_CYCLES(TMO)) uut (
        .clk(clk), .rst(rst), .clear_i(clear_i), .hdr_load_i(hdr_load_i),
        .hdr_done_i(hdr_done_i), .peer_rdy_i(peer_rdy_i), .peer_data_i(peer_data_i),
        .peer_stb_n_o(peer_stb_n_o), .word_rd_i(word_rd_i), .word_o(word_o),
        .seq_o(seq_o), .rdy_o(rdy_o), .fifo_room_o(fifo_room_o), .tto_set_o(tto_set_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FIFO-side FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    // Peer model: offer one byte, wait for the strobe, measure its width.
    task automatic send_byte(input logic [7:0] b);
        int w = 0;
        int lowc = 0;
        @(negedge clk); peer_data_i = b; peer_rdy_i = 1'b1;
        while (peer_stb_n_o && w < 2000) begin @(negedge clk); w++; end
        if (w >= 2000) begin
            peer_rdy_i = 1'b0;
            check(1'b0, "R3 strobe never issued", 32'(w), 32'd0);
            return;
        end
        while (!peer_stb_n_o) begin lowc++; peer_rdy_i = 1'b0; @(negedge clk); end
        check(lowc == STB, "R3 strobe width", 32'(lowc), 32'(STB));
    endtask

    // Driver: expected word goes to the scoreboard before its bytes are sent.
    task automatic send_word(input logic [23:0] w, input bit expect_it);
        if (expect_it) exp_q.push_back(w);
        send_byte(w[23:16]);
        send_byte(w[15:8]);
        send_byte(w[7:0]);
    endtask

    task automatic offer_no_take(input string tag);
        int lows = 0;
        @(negedge clk); peer_data_i = 8'hEE; peer_rdy_i = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!peer_stb_n_o) lows++;
        end
        peer_rdy_i = 1'b0;
        check(lows == 0, tag, 32'(lows), 32'd0);
    endtask

    task automatic drain(input string tag);
        int w = 0;
        while (exp_q.size() != 0 && w < 1000) begin @(negedge clk); w++; end
        check(exp_q.size() == 0, tag, 32'(exp_q.size()), 32'd0);
    endtask

    // Monitor: pops the scoreboard whenever a word is offered and reads it.
    initial begin
        forever begin
            @(negedge clk);
            if (auto_read && rdy_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected word", {8'h0, word_o}, 32'h0);
                end else begin
                    logic [23:0] e;
                    e = exp_q.pop_front();
                    check(word_o == e, "R5 packed word", {8'h0, word_o}, {8'h0, e});
                end
                word_rd_i = 1'b1;
                @(negedge clk);
                word_rd_i = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(peer_stb_n_o && !seq_o && !rdy_o && fifo_room_o && !tto_set_o,
              "R1 reset outputs",
              {27'h0, peer_stb_n_o, seq_o, rdy_o, fifo_room_o, tto_set_o}, 32'h12);

        offer_no_take("R2 ready ignored before header done");
        pulse(hdr_done_i);

        auto_read = 1'b1;
        send_word(24'h010203, 1'b1);
        send_word(24'h040506, 1'b1);
        send_word(24'hFF00A5, 1'b1);
        send_word(24'h5A3CC3, 1'b1);
        drain("R5 scoreboard empty after stream");

        // R8 / R7: hold a word with the next one queued, then read.
        auto_read = 1'b0;
        send_word(24'hA1B2C3, 1'b0);
        send_word(24'hD4E5F6, 1'b0);
        repeat (10) @(negedge clk);
        check(rdy_o && !seq_o && word_o == 24'hA1B2C3, "R8 held word untouched",
              {6'h0, rdy_o, seq_o, word_o}, {8'h2, 24'hA1B2C3});
        word_rd_i = 1'b1;
        @(negedge clk); word_rd_i = 1'b0;
        check(!rdy_o && seq_o, "R7 read with first-byte take",
              {30'h0, rdy_o, seq_o}, 32'h1);
        @(negedge clk); @(negedge clk);
        check(rdy_o && !seq_o && word_o == 24'hD4E5F6, "R6 second word ready",
              {6'h0, rdy_o, seq_o, word_o}, {8'h2, 24'hD4E5F6});
        pulse(word_rd_i);
        check(!rdy_o, "R7 read clears ready", {31'h0, rdy_o}, 32'h0);
        pulse(word_rd_i);
        check(!rdy_o && !seq_o, "R7 read while empty ignored",
              {30'h0, rdy_o, seq_o}, 32'h0);

        // R4 / R10: fill the queue behind a held word.
        for (int i = 0; i < 67; i++) send_byte(8'(i + 16));
        @(negedge clk);
        check(!fifo_room_o, "R4 room low when 64 stored", {31'h0, fifo_room_o}, 32'h0);
        offer_no_take("R4 no take while full");
        pulse(hdr_load_i);
        check(fifo_room_o && rdy_o && word_o == 24'h101112, "R10 flush keeps held word",
              {6'h0, fifo_room_o, rdy_o, word_o}, {8'h3, 24'h101112});
        pulse(word_rd_i);
        repeat (20) @(negedge clk);
        check(!rdy_o && !seq_o, "R10 flushed bytes gone", {30'h0, rdy_o, seq_o}, 32'h0);
        auto_read = 1'b1;
        send_word(24'h778899, 1'b1);
        drain("R10 mask still open after flush");

        // R9: stall after one byte.
        begin
            int w = 0;
            send_byte(8'h42);
            while (!tto_set_o && w < 1000) begin @(negedge clk); w++; end
            check(tto_set_o && !seq_o, "R9 timeout pulse", {30'h0, tto_set_o, seq_o}, 32'h2);
            check(w > TMO - 20 && w < TMO + 20, "R9 timeout window", 32'(w), 32'(TMO));
            @(negedge clk);
            check(!tto_set_o, "R9 single pulse", {31'h0, tto_set_o}, 32'h0);
        end
        send_word(24'h13579B, 1'b1);
        drain("R9 partial word discarded");

        // R11: clear against a held word and a waiting byte.
        auto_read = 1'b0;
        send_word(24'hCAFE01, 1'b0);
        send_byte(8'h99);
        repeat (2) @(negedge clk);
        pulse(clear_i);
        check(peer_stb_n_o && !seq_o && !rdy_o && fifo_room_o && !tto_set_o,
              "R11 R1 outputs after clear",
              {27'h0, peer_stb_n_o, seq_o, rdy_o, fifo_room_o, tto_set_o}, 32'h12);
        offer_no_take("R2 mask re-armed by clear");
        repeat (10) @(negedge clk);
        check(!rdy_o, "R11 held word dropped", {31'h0, rdy_o}, 32'h0);
        pulse(hdr_done_i);
        auto_read = 1'b1;
        send_word(24'h0BEEF0, 1'b1);
        drain("R11 fresh word after clear");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule